// File: doc/BRIEF.md
# Two-Channel Edge Capture Timer

This block timestamps signal edges. A 16-bit counter runs from the CPU clock through a selectable prescaler. Each of two capture channels watches its own input pin. When the pin makes the transition chosen for that channel, the channel stores the counter value in a 16-bit holding register and raises its pending flag. A shared interrupt line is high while interrupts are enabled and either flag is pending.

Software reaches the block through an 8-bit register port. It holds one control byte, one status byte and two bytes per channel for the stored timestamp. A flag is retired by a two-step handshake. First the status byte is read while the flag is up. Then the low timestamp byte of that channel is read or written. The handshake keeps software from dropping a capture it has not yet looked at.

Top module: `icap_unit`

## Requirements
- R1: After synchronous reset the control byte, the status byte, both timestamps, the counter and `irq` are all zero.
- R2: Control bits [4:3] select the counter rate: 00 advances the counter once every 4 clocks, 01 once every 2, 10 once every 8, and 11 freezes it. The prescale count restarts after each advance, and after a rate change an advance happens as soon as that count reaches the new divisor minus one.
- R3: A pin level is first sampled at some clock edge. On the third edge counted from that one, the channel's timestamp takes the counter value held just before that third edge. The synchronizer stages reset to low.
- R4: Control bit c (c = 0, 1) picks the active transition for channel c: 1 means low-to-high and 0 means high-to-low. The opposite transition changes neither the timestamp nor the flag.
- R5: A capture on channel c sets status bit c.
- R6: `irq` equals control bit 2 AND (status bit 0 OR status bit 1).
- R7: Status bit c clears only under one condition: a read of address 1 that saw the bit set, followed by a read or write of channel c's low byte. A low-byte access without that earlier read leaves the flag set.
- R8: A capture that arrives between the status read and the low-byte access keeps the flag set and loads the new timestamp. It also cancels the pending clear, so a fresh status read is needed.
- R9: The timestamp registers ignore writes. A read or write of a high byte does not clear a flag.
- R10: Address map: 0 is control (bits [7:5] are spare and read back as written), 1 is status, 2 and 3 are channel 0 high and low, 4 and 5 are channel 1 high and low. Addresses 6 and 7 read as zero.
- R11: The channels are independent. Finishing the clear sequence on one channel leaves the other channel's flag untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_pin | input | 2 | Asynchronous capture inputs, bit c for channel c |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe, one clock per access |
| wr_en | input | 1 | Write strobe, one clock per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| irq | output | 1 | Pending-capture interrupt level |

## Verification
The embedded properties assume that the read and write strobes are never high together. They also assume that a status read and a low-byte access never fall in the same clock, which a single address bus already guarantees. The stimulus drives one access at a time and changes pins and strobes a few nanoseconds after the rising edge. The properties also treat a pin that is high when reset is released as a fresh rising edge, so the stimulus holds both pins low through reset and for several clocks after it. Pin toggles are spaced at least two clocks apart so that every transition reaches the edge detector.

// File: rtl/icap_pkg.sv
package icap_pkg;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 3;
    localparam int NCH    = 2;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        CK_DIV4 = 2'b00,
        CK_DIV2 = 2'b01,
        CK_DIV8 = 2'b10,
        CK_HOLD = 2'b11
    } ck_sel_e;

    // control byte layout: spare[7:5], rate[4:3], irq enable[2], edge select[1:0]
    typedef struct packed {
        logic [2:0]     spare;
        ck_sel_e        ck;
        logic           ie;
        logic [NCH-1:0] rise;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

    function automatic logic [ADDR_W-1:0] hi_addr(input int c);
        return ADDR_W'(2 + 2 * c);
    endfunction

    function automatic logic [ADDR_W-1:0] lo_addr(input int c);
        return ADDR_W'(3 + 2 * c);
    endfunction

    // prescale count value at which the counter advances
    function automatic logic [PRE_W-1:0] pre_limit(input ck_sel_e s);
        case (s)
            CK_DIV2: return PRE_W'(1);
            CK_DIV4: return PRE_W'(3);
            CK_DIV8: return PRE_W'(7);
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/icap_base.sv
module icap_base
    import icap_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ck_sel_e       sel,
    output logic [CW-1:0] cnt
);
    logic [PRE_W-1:0] pre_q;
    logic             adv;

    always_comb adv = (sel != CK_HOLD) && (pre_q >= pre_limit(sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt   <= '0;
        end else if (adv) begin
            pre_q <= '0;
            cnt   <= cnt + CW'(1);
        end else if (sel != CK_HOLD) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (sel == CK_HOLD) |=> (cnt == $past(cnt)));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1))));
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise,
    output logic evt
);
    logic s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= pin;
            s2   <= s1;
            prev <= s2;
        end
    end

    always_comb evt = (s2 != prev) && (s2 == rise);
endmodule

// File: rtl/icap_chan.sv
module icap_chan
    import icap_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pin,
    input  logic          rise,
    input  logic [CW-1:0] cnt,
    input  logic          stat_rd,
    input  logic          lo_acc,
    output logic          flag,
    output logic [CW-1:0] cap
);
    logic evt;
    logic armed;

    icap_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (pin),
        .rise (rise),
        .evt  (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap   <= '0;
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (evt) begin
            cap   <= cnt;
            flag  <= 1'b1;
            armed <= 1'b0;
        end else if (lo_acc && armed) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (stat_rd && flag) begin
            armed <= 1'b1;
        end
    end

    p_latch_r3: assert property (@(posedge clk) disable iff (rst)
        evt |=> (cap == $past(cnt)));

    p_flag_r5: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag);

    p_noarm_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !armed) |=> flag);

    p_cap_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(cap));
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    cap_pin,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CW = CNT_W;

    ctrl_t          ctrl_q;
    logic [CW-1:0]  cnt;
    logic [NCH-1:0] flags;
    logic [CW-1:0]  cap [NCH];
    logic           stat_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && addr == A_CTRL) begin
            ctrl_q <= ctrl_t'(wdata);
        end
    end

    always_comb stat_rd = rd_en && (addr == A_STAT);

    icap_base #(.CW(CW)) u_base (
        .clk (clk),
        .rst (rst),
        .sel (ctrl_q.ck),
        .cnt (cnt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic lo_acc;
        always_comb lo_acc = (rd_en || wr_en) && (addr == lo_addr(c));

        icap_chan #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .pin     (cap_pin[c]),
            .rise    (ctrl_q.rise[c]),
            .cnt     (cnt),
            .stat_rd (stat_rd),
            .lo_acc  (lo_acc),
            .flag    (flags[c]),
            .cap     (cap[c])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) rdata = ctrl_q;
        if (addr == A_STAT) rdata = DATA_W'(flags);
        for (int c = 0; c < NCH; c++) begin
            if (addr == hi_addr(c)) rdata = cap[c][CW-1:DATA_W];
            if (addr == lo_addr(c)) rdata = cap[c][DATA_W-1:0];
        end
    end

    always_comb irq = ctrl_q.ie && (|flags);

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));
endmodule

// File: tb/sim_icap_unit.sv
module sim_icap_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cap_pin = 2'b00;
    logic [2:0] addr = 3'd0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    icap_unit u0 (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0]  m_ctrl;
    logic [15:0] m_cnt;
    int          m_pre;
    logic [15:0] m_cap [2];
    logic        m_flag [2];
    logic        m_arm [2];
    logic        m_s1 [2];
    logic        m_s2 [2];
    logic        m_prev [2];

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 8'd0; m_cnt = 16'd0; m_pre = 0;
            for (int c = 0; c < 2; c++) begin
                m_cap[c] = 16'd0; m_flag[c] = 0; m_arm[c] = 0;
                m_s1[c] = 0; m_s2[c] = 0; m_prev[c] = 0;
            end
        end else begin
            int div;
            case (m_ctrl[4:3])
                2'b00: div = 4;
                2'b01: div = 2;
                2'b10: div = 8;
                default: div = 0;
            endcase
            for (int c = 0; c < 2; c++) begin
                bit det, lo;
                det = (m_s2[c] != m_prev[c]) && (m_s2[c] == m_ctrl[c]);
                lo  = (rd_en || wr_en) && (addr == 3'(3 + 2 * c));
                if (det) begin
                    m_cap[c] = m_cnt; m_flag[c] = 1; m_arm[c] = 0;
                end else if (lo && m_arm[c]) begin
                    m_flag[c] = 0; m_arm[c] = 0;
                end else if (rd_en && addr == 3'd1 && m_flag[c]) begin
                    m_arm[c] = 1;
                end
            end
            if (div != 0) begin
                if (m_pre >= div - 1) begin
                    m_pre = 0; m_cnt = m_cnt + 16'd1;
                end else begin
                    m_pre = m_pre + 1;
                end
            end
            if (wr_en && addr == 3'd0) m_ctrl = wdata;
            for (int c = 0; c < 2; c++) begin
                m_prev[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = cap_pin[c];
            end
        end
    end

    function automatic logic [7:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return {6'd0, m_flag[1], m_flag[0]};
            3'd2: return m_cap[0][15:8];
            3'd3: return m_cap[0][7:0];
            3'd4: return m_cap[1][15:8];
            3'd5: return m_cap[1][7:0];
            default: return 8'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        if (a == 3'd0 || a > 3'd5) return "R10";
        if (a == 3'd1) return "R5";
        return "R3";
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the reference on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6", 16'(irq), 16'(m_ctrl[2] && (m_flag[0] || m_flag[1])));
            chk(tag_of(addr), 16'(rdata), 16'(m_rd(addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input logic [2:0] a, input logic r, input logic w, input logic [7:0] d);
        @(posedge clk); #2;
        addr = a; rd_en = r; wr_en = w; wdata = d;
        @(posedge clk); #2;
        rd_en = 0; wr_en = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #2;
        addr = a; rd_en = 1;
        @(negedge clk);
        chk(tag, 16'(rdata), 16'(exp));
        @(posedge clk); #2;
        rd_en = 0;
    endtask

    task automatic rd_val(input logic [2:0] a, output logic [7:0] v);
        @(posedge clk); #2;
        addr = a; rd_en = 1;
        @(negedge clk);
        v = rdata;
        @(posedge clk); #2;
        rd_en = 0;
    endtask

    task automatic set_pin(input int c, input logic v);
        @(posedge clk); #2;
        cap_pin[c] = v;
        repeat (4) @(posedge clk);
        #2;
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk);
        chk(tag, 16'(irq), 16'(exp));
    endtask

    task automatic summary;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] h1, l1, h2, l2;
        logic [15:0] lf;
        repeat (5) @(posedge clk);
        #2 rst = 0;
        repeat (3) @(posedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 8'd0, "R1");
        irq_chk(1'b0, "R1");

        // R10: control readback (rate 01, irq on, ch0 rising, ch1 falling)
        drive(3'd0, 0, 1, 8'h0D);
        rd_chk(3'd0, 8'h0D, "R10");

        // R5 / R6: rising edge on channel 0
        set_pin(0, 1);
        irq_chk(1'b1, "R6");

        // R7: low access without prior status read leaves the flag
        drive(3'd3, 0, 1, 8'h55);
        rd_chk(3'd1, 8'h01, "R7");
        drive(3'd3, 1, 0, 8'h00);
        rd_chk(3'd1, 8'h00, "R7");
        irq_chk(1'b0, "R6");

        // R4: edge polarity per channel
        set_pin(1, 1);
        rd_chk(3'd1, 8'h00, "R4");
        set_pin(1, 0);
        rd_chk(3'd1, 8'h02, "R4");
        set_pin(0, 0);
        rd_chk(3'd1, 8'h02, "R4");

        // R11: clearing one channel spares the other
        set_pin(0, 1);
        rd_chk(3'd1, 8'h03, "R11");
        drive(3'd5, 1, 0, 8'h00);
        rd_chk(3'd1, 8'h01, "R11");
        drive(3'd3, 1, 0, 8'h00);
        rd_chk(3'd1, 8'h00, "R11");

        // R9: writes ignored, high-byte access does not clear
        set_pin(0, 0);
        set_pin(0, 1);
        drive(3'd2, 0, 1, 8'hAA);
        drive(3'd3, 0, 0, 8'h00);
        rd_chk(3'd2, m_cap[0][15:8], "R9");
        rd_chk(3'd1, 8'h01, "R9");
        drive(3'd2, 1, 0, 8'h00);
        rd_chk(3'd1, 8'h01, "R9");
        drive(3'd3, 1, 0, 8'h00);
        rd_chk(3'd1, 8'h00, "R9");

        // R8: capture during the clear handshake
        set_pin(0, 0);
        set_pin(0, 1);
        rd_chk(3'd1, 8'h01, "R8");
        set_pin(0, 0);
        set_pin(0, 1);
        drive(3'd3, 1, 0, 8'h00);
        rd_chk(3'd1, 8'h01, "R8");
        rd_chk(3'd3, m_cap[0][7:0], "R8");
        drive(3'd3, 1, 0, 8'h00);
        rd_chk(3'd1, 8'h00, "R8");

        // R6: enable gates the request
        set_pin(0, 0);
        set_pin(0, 1);
        drive(3'd0, 0, 1, 8'h09);
        irq_chk(1'b0, "R6");
        drive(3'd0, 0, 1, 8'h0D);
        irq_chk(1'b1, "R6");
        rd_chk(3'd1, 8'h01, "R6");
        drive(3'd3, 1, 0, 8'h00);

        // R2: frozen counter gives equal timestamps
        drive(3'd0, 0, 1, 8'h1D);
        set_pin(0, 0);
        set_pin(0, 1);
        rd_val(3'd2, h1); rd_val(3'd3, l1);
        rd_chk(3'd1, 8'h01, "R2");
        drive(3'd3, 1, 0, 8'h00);
        repeat (20) @(posedge clk);
        set_pin(0, 0);
        set_pin(0, 1);
        rd_val(3'd2, h2); rd_val(3'd3, l2);
        chk("R2", {h2, l2}, {h1, l1});

        // R10: spare bits and unmapped addresses
        drive(3'd0, 0, 1, 8'hED);
        rd_chk(3'd0, 8'hED, "R10");
        rd_chk(3'd6, 8'h00, "R10");
        rd_chk(3'd7, 8'h00, "R10");

        // mixed traffic under every rate code, checked each clock
        lf = 16'hACE1;
        for (int code = 0; code < 4; code++) begin
            drive(3'd0, 0, 1, {3'd0, 2'(code), lf[0], lf[2:1]});
            for (int i = 0; i < 1200; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                case (lf[2:0])
                    3'd0, 3'd1: begin
                        @(posedge clk); #2;
                        cap_pin[lf[3]] = ~cap_pin[lf[3]];
                        @(posedge clk); #2;
                    end
                    3'd2: drive(3'd1, 1, 0, 8'h00);
                    3'd3: drive(lf[4] ? 3'd5 : 3'd3, lf[5], !lf[5], lf[15:8]);
                    3'd4: drive(lf[4] ? 3'd4 : 3'd2, lf[5], !lf[5], lf[15:8]);
                    3'd5: drive(3'd0, 0, 1, {3'd0, 2'(code), lf[6], lf[8:7]});
                    default: repeat (int'(lf[5:4]) + 1) @(posedge clk);
                endcase
            end
        end

        repeat (4) @(posedge clk);
        summary();
    end
endmodule